// File: doc/BRIEF.md
# Capture and Auto-Reload Timer

This block is an up-counting timer of configurable width with a companion capture/reload register, set up through a single control register. It counts either a divided internal clock or falling edges on an external count pin. A second pin, the trigger pin, can either snapshot the running count into the companion register or force the counter to restart from that register's value. Two sticky flags record counter wrap-around and trigger events so that an interrupt controller can use them.

When either bit-clock select is set, the block acts as a rate generator for a serial transmitter and receiver. It counts at the faster baud prescale, always restarts from the companion register on wrap, and emits a one-cycle transmit and/or receive tick on every wrap. In this mode the trigger pin only raises its flag. Software reads the control, count and companion registers through plain outputs and writes each one with its own strobe.

Top module: `tmr_capreload`

## Requirements
- R1: After synchronous reset the control register, counter and companion register read 0 and both tick outputs are low. Control bit layout: bit0 run, bit1 external count source, bit2 capture select, bit3 trigger enable, bit4 receive-tick select, bit5 transmit-tick select, bit6 trigger flag, bit7 wrap flag.
- R2: With run=1 and the internal source, the counter increments once every TIMER_DIV clocks. The first increment lands TIMER_DIV clocks after the write that sets run. With run=0 the counter holds.
- R3: With run=1 and the external source selected, each falling edge of the count pin adds one to the counter. The pin passes through a two-flop synchronizer, and the counter changes on the third clock edge after the pin is sampled low. With run=0 these edges have no effect.
- R4: With capture select=0 and no bit-clock select, an increment from all ones loads the companion register value into the counter and sets the wrap flag.
- R5: With capture select=1 and no bit-clock select, an increment from all ones wraps the counter to 0 and sets the wrap flag.
- R6: With capture select=1 and trigger enable=1, a trigger-pin falling edge copies the counter into the companion register and sets the trigger flag, whether run is 1 or 0. The counter is left unchanged.
- R7: With capture select=0 and trigger enable=1, a trigger-pin falling edge loads the companion register into the counter and sets the trigger flag.
- R8: With trigger enable=0, trigger-pin edges leave the counter, the companion register and the trigger flag unchanged.
- R9: When either bit-clock select is 1, the capture select is ignored, the counter reloads from the companion register on every wrap, the prescale is BAUD_DIV clocks, and the wrap flag is never set by hardware.
- R10: In bit-clock mode each wrap produces a one-cycle pulse on the receive tick if receive select is 1 and on the transmit tick if transmit select is 1, in the clock after the wrap. Tick spacing is (2^WIDTH - reload) * BAUD_DIV clocks.
- R11: In bit-clock mode with trigger enable=1, a trigger-pin falling edge sets the trigger flag and neither captures nor reloads.
- R12: Only hardware sets the flags, and they stay set until software writes a 0 to them through the control register. A control write replaces the flag bits, but a hardware set in the same cycle wins.
- R13: A software write to the counter takes precedence over any hardware update of the counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wdata | input | WIDTH | Write data for all registers (control uses the low 8 bits) |
| wr_ctrl | input | 1 | Control register write strobe |
| wr_count | input | 1 | Counter write strobe |
| wr_rcap | input | 1 | Companion register write strobe |
| cnt_pin | input | 1 | External count pin, falling edges counted |
| trig_pin | input | 1 | Trigger pin for capture or reload |
| ctrl_q | output | 8 | Control register read value, flags included |
| count_q | output | WIDTH | Counter read value |
| rcap_q | output | WIDTH | Companion capture/reload register read value |
| tx_tick | output | 1 | Transmit bit-clock tick |
| rx_tick | output | 1 | Receive bit-clock tick |

## Verification
The bench builds the block with WIDTH=8, TIMER_DIV=3 and BAUD_DIV=2, so a full wrap takes at most 256 increments and a bit-clock period at most a few hundred clocks. That brings every wrap, reload and capture path within reach of a short run. Start values just below all ones are swept against several reload values and increment counts, and the expected counts come from a small arithmetic model in the bench. Tick spacing is measured for several reload values and compared with (256 - reload) * 2.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CTRL_W = 8;

    // Control register, MSB first: bit7 wrap flag ... bit0 run
    typedef struct packed {
        logic wrap_flag;
        logic trig_flag;
        logic tx_sel;
        logic rx_sel;
        logic trig_en;
        logic cap_sel;
        logic ext_src;
        logic run;
    } tmr_ctrl_t;

    typedef enum logic [1:0] {
        TRIG_NONE    = 2'd0,
        TRIG_CAPTURE = 2'd1,
        TRIG_RELOAD  = 2'd2,
        TRIG_FLAG    = 2'd3
    } trig_act_e;

    function automatic logic baud_mode(input tmr_ctrl_t c);
        return c.tx_sel | c.rx_sel;
    endfunction

    function automatic logic reload_on_wrap(input tmr_ctrl_t c);
        return baud_mode(c) | ~c.cap_sel;
    endfunction

    function automatic trig_act_e trig_action(input tmr_ctrl_t c, input logic fall);
        if (!fall || !c.trig_en) return TRIG_NONE;
        if (baud_mode(c))        return TRIG_FLAG;
        if (c.cap_sel)           return TRIG_CAPTURE;
        return TRIG_RELOAD;
    endfunction

endpackage

// File: rtl/tmr_fall_det.sv
module tmr_fall_det #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic [SYNC:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[SYNC-1:0], pin};
    end

    assign fall = sh[SYNC] & ~sh[SYNC-1];

    // R3: an edge is seen once, never two cycles running
    p_fall_once_r3: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int TIMER_DIV = 12,
    parameter int BAUD_DIV  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic baud,
    output logic tick
);
    localparam int MAXDIV = (TIMER_DIV > BAUD_DIV) ? TIMER_DIV : BAUD_DIV;
    localparam int PW     = $clog2(MAXDIV + 1);

    logic [PW-1:0] pcnt;
    logic [PW-1:0] lim;

    assign lim  = baud ? PW'(BAUD_DIV - 1) : PW'(TIMER_DIV - 1);
    assign tick = run && (pcnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || !run)     pcnt <= '0;
        else if (pcnt >= lim) pcnt <= '0;
        else                 pcnt <= pcnt + PW'(1);
    end

    // R2: a stopped prescaler produces no ticks in the next cycle
    p_stop_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pcnt == '0));

endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  tmr_ctrl_t wdata,
    input  logic      set_wrap,
    input  logic      set_trig,
    output tmr_ctrl_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (wr)       q <= wdata;
            if (set_wrap) q.wrap_flag <= 1'b1;
            if (set_trig) q.trig_flag <= 1'b1;
        end
    end

    // R12: flags are sticky without a control write
    p_trig_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (q.trig_flag && !wr) |=> q.trig_flag);
    p_wrap_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (q.wrap_flag && !wr) |=> q.wrap_flag);
    // R12: hardware set wins over a same-cycle clearing write
    p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
        set_trig |=> q.trig_flag);

endmodule

// File: rtl/tmr_capreload.sv
module tmr_capreload
    import tmr_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int TIMER_DIV = 12,
    parameter int BAUD_DIV  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] wdata,
    input  logic             wr_ctrl,
    input  logic             wr_count,
    input  logic             wr_rcap,
    input  logic             cnt_pin,
    input  logic             trig_pin,
    output logic [7:0]       ctrl_q,
    output logic [WIDTH-1:0] count_q,
    output logic [WIDTH-1:0] rcap_q,
    output logic             tx_tick,
    output logic             rx_tick
);
    localparam int NPIN = 2;
    localparam int PIN_CNT  = 0;
    localparam int PIN_TRIG = 1;

    tmr_ctrl_t   ctrl;
    logic [NPIN-1:0] pins;
    logic [NPIN-1:0] falls;
    logic        baud;
    logic        presc_tick;
    logic        inc;
    logic        wrap;
    trig_act_e   act;
    logic [WIDTH-1:0] count_nxt;
    logic [WIDTH-1:0] rcap_nxt;
    logic        tx_q, rx_q;

    assign pins = {trig_pin, cnt_pin};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        tmr_fall_det #(.SYNC(2)) u_det (
            .clk (clk),
            .rst (rst),
            .pin (pins[g]),
            .fall(falls[g])
        );
    end

    tmr_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_ctrl),
        .wdata   (tmr_ctrl_t'(wdata[CTRL_W-1:0])),
        .set_wrap(wrap & ~baud),
        .set_trig(act != TRIG_NONE),
        .q       (ctrl)
    );

    assign baud = baud_mode(ctrl);

    tmr_prescale #(.TIMER_DIV(TIMER_DIV), .BAUD_DIV(BAUD_DIV)) u_presc (
        .clk (clk),
        .rst (rst),
        .run (ctrl.run & ~ctrl.ext_src),
        .baud(baud),
        .tick(presc_tick)
    );

    assign inc  = ctrl.run & ~wr_count &
                  (ctrl.ext_src ? falls[PIN_CNT] : presc_tick);
    assign wrap = inc & (count_q == '1);
    assign act  = trig_action(ctrl, falls[PIN_TRIG]);

    always_comb begin
        count_nxt = count_q;
        if (inc) begin
            if (wrap) count_nxt = reload_on_wrap(ctrl) ? rcap_q : '0;
            else      count_nxt = count_q + WIDTH'(1);
        end
        if (act == TRIG_RELOAD) count_nxt = rcap_q;
        if (wr_count)           count_nxt = wdata;
    end

    always_comb begin
        rcap_nxt = rcap_q;
        if (act == TRIG_CAPTURE) rcap_nxt = count_q;
        if (wr_rcap)             rcap_nxt = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            rcap_q  <= '0;
            tx_q    <= 1'b0;
            rx_q    <= 1'b0;
        end else begin
            count_q <= count_nxt;
            rcap_q  <= rcap_nxt;
            tx_q    <= wrap & baud & ctrl.tx_sel;
            rx_q    <= wrap & baud & ctrl.rx_sel;
        end
    end

    assign ctrl_q  = ctrl;
    assign tx_tick = tx_q;
    assign rx_tick = rx_q;

    // R2: stopped counter holds unless written or trigger-reloaded
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !wr_count && act != TRIG_RELOAD) |=> $stable(count_q));
    // R4: reload on wrap takes the companion value
    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (wrap && reload_on_wrap(ctrl) && !wr_count) |=> (count_q == $past(rcap_q)));
    // R6: capture copies the counter
    p_capture_r6: assert property (@(posedge clk) disable iff (rst)
        (act == TRIG_CAPTURE && !wr_rcap) |=> (rcap_q == $past(count_q)));
    // R9: bit-clock mode never raises the wrap flag by hardware
    p_no_wrapflag_r9: assert property (@(posedge clk) disable iff (rst)
        (baud && !wr_ctrl) |=> !$rose(ctrl.wrap_flag));
    // R10: ticks are single-cycle pulses
    p_tx_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        tx_tick |=> !tx_tick);
    p_rx_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rx_tick |=> !rx_tick);
    // R13: a counter write lands as written
    p_write_wins_r13: assert property (@(posedge clk) disable iff (rst)
        wr_count |=> (count_q == $past(wdata)));

endmodule

// File: tb/tb_tmr_capreload.sv
module tb_tmr_capreload;
    localparam int W  = 8;
    localparam int TD = 3;
    localparam int BD = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] wdata = '0;
    logic         wr_ctrl = 1'b0, wr_count = 1'b0, wr_rcap = 1'b0;
    logic         cnt_pin = 1'b1, trig_pin = 1'b1;
    logic [7:0]   ctrl_q;
    logic [W-1:0] count_q, rcap_q;
    logic         tx_tick, rx_tick;

    int total = 0;
    int bad   = 0;
    int cyc_n = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc_n <= cyc_n + 1;

    tmr_capreload #(.WIDTH(W), .TIMER_DIV(TD), .BAUD_DIV(BD)) dut (
        .clk(clk), .rst(rst), .wdata(wdata),
        .wr_ctrl(wr_ctrl), .wr_count(wr_count), .wr_rcap(wr_rcap),
        .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .ctrl_q(ctrl_q), .count_q(count_q), .rcap_q(rcap_q),
        .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    // which: 0 ctrl, 1 count, 2 rcap
    task automatic wr(input int which, input int val);
        wdata    = W'(val);
        wr_ctrl  = (which == 0);
        wr_count = (which == 1);
        wr_rcap  = (which == 2);
        @(posedge clk);
        #1;
        wr_ctrl = 1'b0; wr_count = 1'b0; wr_rcap = 1'b0;
    endtask

    task automatic trig_fall();
        trig_pin = 1'b0; cyc(4);
        trig_pin = 1'b1; cyc(4);
    endtask

    task automatic cnt_fall();
        cnt_pin = 1'b0; cyc(2);
        cnt_pin = 1'b1; cyc(2);
    endtask

    task automatic wait_tick(input bit use_tx, output int at);
        at = -1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (use_tx ? tx_tick : rx_tick) begin
                at = cyc_n;
                return;
            end
        end
    endtask

    initial begin
        int exp_c, at0, at1, other;
        bit wrapped;

        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ctrl", ctrl_q, 0);
        chk("R1", "count", count_q, 0);
        chk("R1", "rcap", rcap_q, 0);
        chk("R1", "ticks", {tx_tick, rx_tick}, 0);
        #1;

        // R2 internal counting sweep, then hold
        for (int n = 1; n <= 8; n++) begin
            wr(0, 8'h00); wr(1, 8'h20); wr(0, 8'h01);
            cyc(n * TD - 1);
            wr(0, 8'h00);
            @(negedge clk);
            chk("R2", "count after run", count_q, 8'h20 + n);
            cyc(10);
            chk("R2", "hold while stopped", count_q, 8'h20 + n);
        end

        // R3 external counting, and ignored while stopped
        for (int n = 0; n <= 5; n++) begin
            wr(0, 8'h00); wr(1, 8'h10); wr(0, 8'h03);
            for (int p = 0; p < n; p++) cnt_fall();
            cyc(3);
            wr(0, 8'h02);
            @(negedge clk);
            chk("R3", "external count", count_q, 8'h10 + n);
            #1;
            cnt_fall(); cnt_fall();
            chk("R3", "stopped ignores pin", count_q, 8'h10 + n);
        end

        // R4 / R5 wrap sweeps near all ones
        for (int mode = 0; mode < 2; mode++) begin
            for (int ri = 0; ri < 3; ri++) begin
                for (int si = 0; si < 3; si++) begin
                    for (int n = 1; n <= 5; n++) begin
                        int r, s;
                        r = (ri == 0) ? 8'h00 : (ri == 1) ? 8'h80 : 8'hFD;
                        s = (si == 0) ? 8'hFC : (si == 1) ? 8'hFE : 8'hFF;
                        wr(0, 8'h00); wr(2, r); wr(1, s);
                        wr(0, mode ? 8'h05 : 8'h01);
                        cyc(n * TD - 1);
                        wr(0, ctrl_q & 8'hC0);
                        exp_c = s; wrapped = 0;
                        for (int k = 0; k < n; k++) begin
                            if (exp_c == 8'hFF) begin
                                exp_c = mode ? 0 : r; wrapped = 1;
                            end else exp_c = exp_c + 1;
                        end
                        @(negedge clk);
                        chk(mode ? "R5" : "R4", "count", count_q, exp_c);
                        chk(mode ? "R5" : "R4", "wrap flag", ctrl_q[7], wrapped);
                        #1;
                    end
                end
            end
        end

        // R6 capture, R7 trigger reload, R8 trigger disabled
        for (int vi = 0; vi < 3; vi++) begin
            int v;
            v = (vi == 0) ? 8'h00 : (vi == 1) ? 8'h5A : 8'hFF;
            wr(0, 8'h0C); wr(2, 8'h11); wr(1, v);
            trig_fall();
            chk("R6", "captured", rcap_q, v);
            chk("R6", "count kept", count_q, v);
            chk("R6", "trig flag", ctrl_q[6], 1);

            wr(0, 8'h08); wr(2, 8'h33 + vi); wr(1, v);
            trig_fall();
            chk("R7", "reloaded", count_q, 8'h33 + vi);
            chk("R7", "trig flag", ctrl_q[6], 1);

            wr(0, vi[0] ? 8'h04 : 8'h00); wr(2, 8'h44); wr(1, v);
            trig_fall();
            chk("R8", "rcap kept", rcap_q, 8'h44);
            chk("R8", "count kept", count_q, v);
            chk("R8", "no flag", ctrl_q[6], 0);
        end

        // R12 flags sticky, cleared by software write
        wr(0, 8'h0C); wr(1, 8'h01); trig_fall();
        cyc(10);
        chk("R12", "flag sticky", ctrl_q[6], 1);
        wr(0, 8'h0C);
        chk("R12", "flag cleared", ctrl_q, 8'h0C);

        // R13 counter write beats same-cycle trigger reload
        wr(0, 8'h08); wr(2, 8'h40); wr(1, 8'h10);
        trig_pin = 1'b0; cyc(2);
        wr(1, 8'h77);
        chk("R13", "write wins", count_q, 8'h77);
        chk("R13", "flag still set", ctrl_q[6], 1);
        trig_pin = 1'b1; cyc(4);
        chk("R13", "no late reload", count_q, 8'h77);

        // R9 / R10 bit-clock spacing and selects
        for (int ri = 0; ri < 4; ri++) begin
            int r;
            r = (ri == 0) ? 8'hFF : (ri == 1) ? 8'hFE : (ri == 2) ? 8'hFC : 8'hF9;
            for (int sel = 0; sel < 2; sel++) begin
                wr(0, 8'h00); wr(2, r); wr(1, r);
                wr(0, sel ? 8'h25 : 8'h15);
                wait_tick(sel[0], at0);
                wait_tick(sel[0], at1);
                chk("R10", "tick spacing", at1 - at0, (256 - r) * BD);
                other = 0;
                for (int i = 0; i < 100; i++) begin
                    @(negedge clk);
                    if (sel ? rx_tick : tx_tick) other++;
                end
                chk("R10", "other tick idle", other, 0);
                chk("R9", "no wrap flag", ctrl_q[7], 0);
                chk("R9", "count in reload range", (count_q >= r) ? 1 : 0, 1);
                #1;
            end
        end

        // R11 trigger in bit-clock mode only flags
        wr(0, 8'h1C); wr(2, 8'h21); wr(1, 8'h65);
        trig_fall();
        chk("R11", "count kept", count_q, 8'h65);
        chk("R11", "rcap kept", rcap_q, 8'h21);
        chk("R11", "trig flag", ctrl_q[6], 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule